// File: doc/BRIEF.md
# Comma-Aligning Serial-to-Parallel Receiver

This block turns a sampled serial bit stream into 10-bit parallel words. It runs on the recovered bit clock and takes one bit per clock. A loopback enable picks the bit source: either the external serial input or an internal wrap stream that comes back from a transmitter. The first bit received lands in bit 0 of each output word.

While byte synchronisation is enabled, the block watches the stream for the 8B/10B comma. When it finds one, it moves the word boundary so that the comma begins a new word. A comma flag marks every word whose low seven bits hold a comma. With synchronisation disabled, the boundary is frozen wherever it last was.

The block also produces two byte clocks in antiphase. Each one toggles on every finished word, so the two run at half the word rate. Successive words therefore line up with the rising edges of the two clocks in turn.

Top module: `comma_deser`

## Requirements
- R1: While rstN is low, wordOut is 0, wordValid and commaFlag are 0, byteClkA is 0 and byteClkB is 1. The bit history clears to all zeros, and the first bit after reset starts a new word.
- R2: When loopEn is 1, the bit taken on each bit clock is wrapIn and serIn has no effect. When loopEn is 0, the bit taken is serIn.
- R3: A word is delivered after every 10 accepted bits. wordValid is high for exactly the one clock that follows the edge at which the tenth bit was sampled. wordOut bit i holds the i-th bit of that word in arrival order, with bit 0 first.
- R4: A comma is seven consecutive received bits c0..c6 equal to 0,0,1,1,1,1,1 or to 1,1,0,0,0,0,0, with c0 received first. When syncEn is 1 and the bit just taken completes a comma, the boundary moves so that c0 becomes bit 0 of the next delivered word. The bits of the partly collected word are dropped. A word that the same bit completes is still delivered.
- R5: When syncEn is 0, commas never move the word boundary. Words keep coming every 10 bits from the existing boundary.
- R6: commaFlag is high together with wordValid exactly when wordOut bits 0 to 6 hold a comma as defined in R4. Otherwise it is low.
- R7: byteClkA toggles at each word delivery and holds otherwise. byteClkB is always its inverse. Words therefore alternate between the rising edges of byteClkA and byteClkB.
- R8: wordOut holds its value between deliveries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock, one bit per rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| serIn | input | 1 | External serial bit |
| wrapIn | input | 1 | Internal loopback serial bit |
| loopEn | input | 1 | 1 selects wrapIn, 0 selects serIn |
| syncEn | input | 1 | 1 enables comma realignment, 0 freezes the boundary |
| wordOut | output | 10 | Recovered parallel word, bit 0 received first |
| wordValid | output | 1 | One-clock strobe marking a newly delivered word |
| commaFlag | output | 1 | Delivered word carries an aligned comma |
| byteClkA | output | 1 | Byte clock, toggles on each delivery |
| byteClkB | output | 1 | Byte clock in antiphase to byteClkA |

## Verification
The tenth bit of a word, its comma flag and the byte-clock toggle all take effect at the same rising edge of the bit clock. That edge is the one that samples the tenth bit. A realignment takes effect at the edge that samples a comma's seventh bit, and the aligned word appears three bits later. The bench applies each bit at a falling edge and steps a behavioural model for it. At the next falling edge it compares every output with the model, one register stage after the bit was sampled. Directed checks confirm that the aligned word equals the comma sent, and that no flag appears while misaligned commas arrive with synchronisation off.

// File: rtl/deser_pkg.sv
package deser_pkg;
  // Strobes passed from the boundary control to the datapath each bit clock.
  typedef struct packed {
    logic wordStb;   // current bit completes a word
    logic flagWord;  // completed word begins with an aligned comma
  } deserStrb_t;
endpackage

// File: rtl/deser_datapath.sv
module deser_datapath
  import deser_pkg::*;
#(
  parameter int WORD_W  = 10,
  parameter int COMMA_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serIn,
  input  logic              wrapIn,
  input  logic              loopEn,
  input  deserStrb_t        strb,
  output logic              commaHit,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordValid,
  output logic              commaFlag,
  output logic              byteClkA,
  output logic              byteClkB
);
  // Comma in arrival order c0..c6 = 0,0,1,1,1,1,1 (vector LSB = c0).
  localparam logic [COMMA_W-1:0] COMMA_BASE = COMMA_W'(7'b1111100);

  logic              bitIn;
  logic [WORD_W-1:0] win;
  logic [WORD_W-1:0] nextWin;
  logic [1:0]        polHit;

  assign bitIn   = loopEn ? wrapIn : serIn;
  // Oldest bit sits at index 0, the newest enters at the top.
  assign nextWin = {bitIn, win[WORD_W-1:1]};

  // One matcher per comma polarity; the newest COMMA_W bits are compared.
  for (genvar g = 0; g < 2; g++) begin : g_pol
    localparam logic [COMMA_W-1:0] PAT = (g == 0) ? COMMA_BASE : ~COMMA_BASE;
    assign polHit[g] = (nextWin[WORD_W-1:WORD_W-COMMA_W] == PAT);
  end
  assign commaHit = |polHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      win       <= '0;
      wordOut   <= '0;
      wordValid <= 1'b0;
      commaFlag <= 1'b0;
      byteClkA  <= 1'b0;
      byteClkB  <= 1'b1;
    end else begin
      win       <= nextWin;
      wordValid <= strb.wordStb;
      commaFlag <= strb.wordStb & strb.flagWord;
      if (strb.wordStb) begin
        wordOut  <= nextWin;
        byteClkA <= ~byteClkA;
        byteClkB <= ~byteClkB;
      end
    end
  end
endmodule

// File: rtl/deser_control.sv
module deser_control
  import deser_pkg::*;
#(
  parameter int WORD_W  = 10,
  parameter int COMMA_W = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncEn,
  input  logic       commaHit,
  output deserStrb_t strb
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] ALIGNED  = CNT_W'(COMMA_W);

  logic [CNT_W-1:0] bitCnt;    // bits already held for the current word
  logic [CNT_W-1:0] cntNorm;
  logic [CNT_W-1:0] cntNext;
  logic             realign;
  logic             alignedHit;
  logic             pending;

  assign cntNorm    = (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
  assign realign    = syncEn & commaHit;
  assign cntNext    = realign ? ALIGNED : cntNorm;
  // A comma whose first bit opens the word under collection.
  assign alignedHit = commaHit & (cntNext == ALIGNED);

  assign strb.wordStb  = (bitCnt == LAST_BIT);
  assign strb.flagWord = pending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      pending <= 1'b0;
    end else begin
      bitCnt <= cntNext;
      if (strb.wordStb || realign) pending <= alignedHit;
      else                         pending <= pending | alignedHit;
    end
  end
endmodule

// File: rtl/comma_deser.sv
module comma_deser
  import deser_pkg::*;
#(
  parameter int WORD_W  = 10,
  parameter int COMMA_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serIn,
  input  logic              wrapIn,
  input  logic              loopEn,
  input  logic              syncEn,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordValid,
  output logic              commaFlag,
  output logic              byteClkA,
  output logic              byteClkB
);
  deserStrb_t strb;
  logic       commaHit;

  deser_control #(.WORD_W(WORD_W), .COMMA_W(COMMA_W)) u_ctl (
    .clk(clk), .rstN(rstN), .syncEn(syncEn), .commaHit(commaHit), .strb(strb)
  );

  deser_datapath #(.WORD_W(WORD_W), .COMMA_W(COMMA_W)) u_dp (
    .clk(clk), .rstN(rstN), .serIn(serIn), .wrapIn(wrapIn), .loopEn(loopEn),
    .strb(strb), .commaHit(commaHit), .wordOut(wordOut), .wordValid(wordValid),
    .commaFlag(commaFlag), .byteClkA(byteClkA), .byteClkB(byteClkB)
  );
endmodule

// File: rtl/comma_deser_chk.sv
module comma_deser_chk #(
  parameter int WORD_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic [WORD_W-1:0] wordOut,
  input logic              wordValid,
  input logic              commaFlag,
  input logic              byteClkA,
  input logic              byteClkB
);
  logic lowComma;
  assign lowComma = (wordOut[6:0] == 7'b1111100) || (wordOut[6:0] == 7'b0000011);

  p_antiphase_r7: assert property (@(posedge clk) disable iff (!rstN)
    byteClkA != byteClkB);
  p_toggle_r7: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> (byteClkA != $past(byteClkA)));
  p_clk_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !wordValid |-> $stable(byteClkA));
  p_flag_comma_r6: assert property (@(posedge clk) disable iff (!rstN)
    commaFlag |-> (wordValid && lowComma));
  p_word_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !wordValid |-> $stable(wordOut));
  p_strobe_gap_r3: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);
endmodule

bind comma_deser comma_deser_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .wordOut(wordOut), .wordValid(wordValid),
  .commaFlag(commaFlag), .byteClkA(byteClkA), .byteClkB(byteClkB)
);

// File: tb/sim_comma_deser.sv
module sim_comma_deser;
  localparam logic [9:0] COMMA_P = 10'h17C; // arrival order 0,0,1,1,1,1,1,0,1,0
  localparam logic [9:0] ALT_W   = 10'h155;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serIn = 1'b0, wrapIn = 1'b0, loopEn = 1'b0, syncEn = 1'b0;
  logic [9:0] wordOut;
  logic wordValid, commaFlag, byteClkA, byteClkB;

  int vectors = 0;
  int misses = 0;
  int cycles = 0;
  int flagSeen = 0;
  logic [9:0] lastWord = '0;

  // Behavioural reference state
  bit  histQ[$];
  int  bitsHave;
  logic [9:0] expWord;
  logic expValid, expFlag, expA;

  comma_deser u0 (
    .clk(clk), .rstN(rstN), .serIn(serIn), .wrapIn(wrapIn), .loopEn(loopEn),
    .syncEn(syncEn), .wordOut(wordOut), .wordValid(wordValid),
    .commaFlag(commaFlag), .byteClkA(byteClkA), .byteClkB(byteClkB)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      misses++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 50000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  function automatic bit isComma(bit p0, bit p1, bit p2, bit p3, bit p4, bit p5, bit p6);
    return (p0 == p1) && (p1 != p2) && (p2 == p3) && (p3 == p4) && (p4 == p5) && (p5 == p6);
  endfunction

  task automatic modelReset();
    histQ.delete();
    for (int i = 0; i < 10; i++) histQ.push_back(1'b0);
    bitsHave = 0;
    expWord = '0; expValid = 1'b0; expFlag = 1'b0; expA = 1'b0;
  endtask

  task automatic modelStep(input bit b, input bit se);
    bit hit;
    histQ.push_back(b);
    void'(histQ.pop_front());
    hit = isComma(histQ[3], histQ[4], histQ[5], histQ[6], histQ[7], histQ[8], histQ[9]);
    bitsHave++;
    expValid = 1'b0;
    expFlag  = 1'b0;
    if (bitsHave == 10) begin
      for (int i = 0; i < 10; i++) expWord[i] = histQ[i];
      expValid = 1'b1;
      expFlag  = isComma(histQ[0], histQ[1], histQ[2], histQ[3], histQ[4], histQ[5], histQ[6]);
      expA     = ~expA;
      bitsHave = 0;
    end
    if (se && hit) bitsHave = 7;
  endtask

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp, input string what);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s: actual %h expected %h at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  task automatic compare(input string tag);
    chk(expValid ? tag : "R8", wordOut, expWord, "wordOut");
    chk("R3", {9'b0, wordValid}, {9'b0, expValid}, "wordValid");
    chk("R6", {9'b0, commaFlag}, {9'b0, expFlag}, "commaFlag");
    chk("R7", {9'b0, byteClkA}, {9'b0, expA}, "byteClkA");
    chk("R7", {9'b0, byteClkB}, {9'b0, ~expA}, "byteClkB");
    if (commaFlag) flagSeen++;
    if (wordValid) lastWord = wordOut;
  endtask

  task automatic step(input bit sb, input bit wb, input bit le, input bit se, input string tag);
    @(negedge clk);
    compare(tag);
    rstN = 1'b1; serIn = sb; wrapIn = wb; loopEn = le; syncEn = se;
    modelStep(le ? wb : sb, se);
  endtask

  task automatic sendWord(input logic [9:0] w, input bit le, input bit se, input string tag);
    for (int i = 0; i < 10; i++) begin
      if (le) step(~w[i], w[i], 1'b1, se, tag);
      else    step(w[i], $urandom_range(1), 1'b0, se, tag);
    end
  endtask

  initial begin
    modelReset();
    // R1: reset state held over several edges
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      compare("R1");
    end
    // R3: plain deserialisation, boundary from reset
    for (int i = 0; i < 80; i++) step($urandom_range(1), $urandom_range(1), 1'b0, 1'b0, "R3");

    // R4: comma at an arbitrary offset with sync on
    for (int i = 0; i < 3; i++) step($urandom_range(1), 1'b0, 1'b0, 1'b1, "R4");
    sendWord(COMMA_P, 1'b0, 1'b1, "R4");
    step(1'b1, 1'b0, 1'b0, 1'b1, "R4");
    chk("R4", lastWord, COMMA_P, "aligned comma word");
    sendWord(ALT_W, 1'b0, 1'b1, "R4");
    for (int k = 0; k < 25; k++) begin
      for (int i = 0; i < $urandom_range(13); i++) step($urandom_range(1), 1'b0, 1'b0, 1'b1, "R4");
      sendWord(k[0] ? ~COMMA_P : COMMA_P, 1'b0, 1'b1, "R4");
      sendWord(ALT_W, 1'b0, 1'b1, "R4");
    end

    // R5: establish a boundary, then freeze it and send misaligned commas
    sendWord(COMMA_P, 1'b0, 1'b1, "R5");
    for (int i = 0; i < 4; i++) step(i[0], 1'b0, 1'b0, 1'b0, "R5");
    flagSeen = 0;
    for (int k = 0; k < 6; k++) begin
      sendWord(COMMA_P, 1'b0, 1'b0, "R5");
      sendWord(ALT_W, 1'b0, 1'b0, "R5");
    end
    step(1'b0, 1'b0, 1'b0, 1'b0, "R5");
    chk("R5", flagSeen[9:0], 10'd0, "flags with sync off");

    // R2: loopback takes wrapIn, serIn carries the opposite bit
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b1, 1'b1, "R2");
    sendWord(COMMA_P, 1'b1, 1'b1, "R2");
    step(1'b1, 1'b0, 1'b1, 1'b1, "R2");
    chk("R2", lastWord, COMMA_P, "word from wrap stream");
    for (int k = 0; k < 20; k++) begin
      sendWord(10'($urandom), 1'b1, 1'b1, "R2");
      if (k % 4 == 0) sendWord(~COMMA_P, 1'b1, 1'b1, "R2");
    end

    // Mixed: random source, sync and loop settings
    for (int i = 0; i < 1500; i++)
      step($urandom_range(1), $urandom_range(1), (i / 200) % 2 == 1, (i / 300) % 2 == 0, "R3");
    @(negedge clk);
    compare("R3");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule